// File: doc/BRIEF.md
# Policy-Selectable Data Cache Controller

This block is a small direct-mapped data cache between a CPU load/store port and a word-wide main-memory bus. A 3-bit policy input, which may change while the cache is idle, selects how write hits, write misses and evictions are handled: write-back with allocation, write-through with allocation, write-through without allocation, or no caching at all. Read misses always fill the whole line. Another bus master may change memory behind the cache. Such changes are never seen by the cache, so software must drop stale lines with per-line maintenance commands.

The CPU sees two aliased address windows onto the same physical memory. A window spanning 0x8000_0000 to 0x9FFF_FFFF is cacheable. A second window spanning 0xA000_0000 to 0xBFFF_FFFF always goes straight to the bus. The physical address is the CPU address with its top three bits cleared. The CPU holds a request stable until `cpu_ready` is high for one cycle. The memory side holds `mem_req` with a stable address until `mem_ack` is high for one cycle, and moves one word per acknowledged transfer. The geometry is 16 lines of four 32-bit words. Tag, index and word fields are taken from the physical address: word in bits 3:2, index in bits 7:4, tag in bits 28:8.

Top module: `polcache`

## Requirements
- R1: `policy` code 3 selects write-back with write allocate, 1 selects write-through with write allocate, 0 selects write-through without write allocate, and 2 or any of 4 to 7 selects uncached. In uncached mode every access, including one to the cacheable window, is a single bus transfer.
- R2: Only addresses with bits 31:29 equal to 3'b100 are cacheable. Every other address, including the uncached window 3'b101 and addresses outside both windows, is served as a single bus transfer. The bus address is always the CPU address with bits 31:29 cleared.
- R3: With no request pending after reset, `cpu_ready` and `mem_req` are low. A cacheable read that hits returns the line word with `cpu_ready` high in the request's first cycle and causes no bus transfer.
- R4: A cacheable read miss fetches the four words of the line in ascending address order, starting at the line-aligned address, and then returns the requested word. `mem_req`, `mem_we` and `mem_addr` hold steady until each transfer is acknowledged.
- R5: In write-back mode a write hit changes only the cache word, marks the line dirty and completes in its first cycle with no bus transfer.
- R6: A miss that replaces a valid dirty line first writes the four old words to their own addresses in ascending order. All four writes are acknowledged before the first refill read starts.
- R7: In either write-through mode every CPU write issues exactly one bus write, including back-to-back writes to the same word. A write hit also updates the line. Lines never become dirty, so a later eviction writes nothing back.
- R8: In write-through without allocate mode a write miss issues one bus write and no read, and leaves the line unfilled. A write hit updates both the line and memory.
- R9: In either allocating mode a write miss first fills the line with four reads and then applies the write. In write-back mode that write makes no bus transfer. In write-through with allocate mode it makes exactly one bus write.
- R10: An access through the uncached window never reads from or modifies the cache. A read returns the memory word even when the line is cached. A write updates memory and leaves the cached copy as it was.
- R11: Changes made to memory by another master are not seen by cacheable reads that hit. The stale value is returned until the line is invalidated.
- R12: `cpu_op` = 1 (invalidate) clears the valid bit of the line selected by the address index. It completes in its first cycle with no bus transfer, and any dirty data in the line is discarded.
- R13: `cpu_op` = 2 (writeback-invalidate) on a valid dirty line writes its four words to memory and then clears the valid bit, with `cpu_ready` in the cycle of the last acknowledge. On a clean or invalid line it clears the valid bit in its first cycle with no bus transfer. `cpu_op` = 0 or 3 is a normal access.
- R14: Changing `policy` from a caching code to an uncached code invalidates every line without writing any dirty data back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| policy | input | 3 | Coherency policy code |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_op | input | 2 | 0/3 access, 1 invalidate line, 2 writeback-invalidate line |
| cpu_addr | input | 32 | CPU byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Bus transfer request, held until `mem_ack` |
| mem_we | output | 1 | Bus transfer is a write |
| mem_addr | output | 32 | Physical word address of the transfer |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Transfer accepted this cycle |
| mem_rdata | input | 32 | Bus read data, valid with `mem_ack` |

## Verification
The bench memory acknowledges one cycle after it sees a request, so every word transfer costs two cycles. Counting the cycles after the request is presented, the result of a hit or a write-back write hit is due in cycle 0, a single bus transfer in cycle 2, a clean miss in cycle 9 (eight cycles of fill, then the hit), and a dirty miss in cycle 17. A writeback-invalidate of a dirty line is due in cycle 8, and a write-through write miss with allocation in cycle 11. Each access task samples `cpu_ready` 1 ns after the falling edge, counts the falling edges until it is seen, and compares that count with the figure above. It then inspects the bus transfers logged during that access: how many reads and how many writes there were, and in what address order.

// File: rtl/polcache_pkg.sv
package polcache_pkg;

  localparam logic [2:0] POL_WTNA = 3'd0;
  localparam logic [2:0] POL_WTWA = 3'd1;
  localparam logic [2:0] POL_UNC  = 3'd2;
  localparam logic [2:0] POL_WBWA = 3'd3;

  localparam logic [1:0] OP_ACCESS = 2'd0;
  localparam logic [1:0] OP_INV    = 2'd1;
  localparam logic [1:0] OP_WBINV  = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_EVICT  = 2'd1,
    S_FILL   = 2'd2,
    S_BYPASS = 2'd3
  } cst_e;

  function automatic logic pol_uncached(input logic [2:0] p);
    return !(p == POL_WTNA || p == POL_WTWA || p == POL_WBWA);
  endfunction

endpackage

// File: rtl/polcache_alias.sv
module polcache_alias (
  input  logic [31:0] vaddr,
  output logic [31:0] paddr,
  output logic        cacheable
);
  assign cacheable = (vaddr[31:29] == 3'b100);
  assign paddr     = {3'b000, vaddr[28:0]};
endmodule

// File: rtl/polcache_store.sv
module polcache_store #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int TW    = 21,
  localparam int IW   = $clog2(LINES),
  localparam int OW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  input  logic [OW-1:0]    wsel,
  input  logic [DW-1:0]    wdata,
  input  logic [TW-1:0]    tag_in,
  input  logic             wr_word,
  input  logic             set_dirty,
  input  logic             fill_last,
  input  logic             clr_valid,
  input  logic             flush,
  output logic [TW-1:0]    rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [DW-1:0]    rd_word,
  output logic [LINES-1:0] valid_vec,
  output logic [LINES-1:0] dirty_vec
);
  logic [DW-1:0]    data_q [LINES][WORDS];
  logic [TW-1:0]    tag_q  [LINES];
  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;

  always_ff @(posedge clk) begin
    if (wr_word) data_q[idx][wsel] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (fill_last) tag_q[idx] <= tag_in;
  end

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (flush) begin
      valid_d = '0;
      dirty_d = '0;
    end else begin
      if (fill_last) begin
        valid_d[idx] = 1'b1;
        dirty_d[idx] = 1'b0;
      end
      if (set_dirty) dirty_d[idx] = 1'b1;
      if (clr_valid) begin
        valid_d[idx] = 1'b0;
        dirty_d[idx] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  assign rd_tag    = tag_q[idx];
  assign rd_valid  = valid_q[idx];
  assign rd_dirty  = dirty_q[idx];
  assign rd_word   = data_q[idx][wsel];
  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;

  AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_last && !flush && !clr_valid) |=> valid_q[$past(idx)]); // R4
endmodule

// File: rtl/polcache_fsm.sv
module polcache_fsm
  import polcache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int TW    = 21,
  localparam int IW   = $clog2(LINES),
  localparam int OW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    policy,
  input  logic          req,
  input  logic          we,
  input  logic [1:0]    op,
  input  logic          cacheable,
  input  logic [TW-1:0] a_tag,
  input  logic [IW-1:0] a_idx,
  input  logic [OW-1:0] a_word,
  input  logic [31:0]   paddr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [TW-1:0] line_tag,
  input  logic          line_valid,
  input  logic          line_dirty,
  input  logic [DW-1:0] line_word,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [OW-1:0] st_wsel,
  output logic [DW-1:0] st_wdata,
  output logic          st_wr_word,
  output logic          st_set_dirty,
  output logic          st_fill_last,
  output logic          st_clr_valid,
  output logic          st_flush
);
  localparam logic [OW-1:0] LAST = OW'(WORDS - 1);

  cst_e          state_q, state_d;
  logic [OW-1:0] beat_q, beat_d;
  logic          maint_q, maint_d;
  logic          upd_q, upd_d;
  logic [2:0]    pol_q;
  logic          hit, bypass, victim_dirty;

  assign hit          = line_valid && (line_tag == a_tag);
  assign bypass       = !cacheable || pol_uncached(policy);
  assign victim_dirty = line_valid && line_dirty;
  assign st_flush     = pol_uncached(policy) && !pol_uncached(pol_q);

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    maint_d      = maint_q;
    upd_d        = upd_q;
    cpu_ready    = 1'b0;
    st_wr_word   = 1'b0;
    st_set_dirty = 1'b0;
    st_fill_last = 1'b0;
    st_clr_valid = 1'b0;
    st_wsel      = a_word;
    st_wdata     = cpu_wdata;
    unique case (state_q)
      S_IDLE: begin
        if (req) begin
          if (op == OP_INV) begin
            st_clr_valid = 1'b1;
            cpu_ready    = 1'b1;
          end else if (op == OP_WBINV) begin
            if (victim_dirty) begin
              state_d = S_EVICT;
              beat_d  = '0;
              maint_d = 1'b1;
            end else begin
              st_clr_valid = 1'b1;
              cpu_ready    = 1'b1;
            end
          end else if (bypass) begin
            state_d = S_BYPASS;
            upd_d   = 1'b0;
          end else if (hit) begin
            if (!we) begin
              cpu_ready = 1'b1;
            end else if (policy == POL_WBWA) begin
              st_wr_word   = 1'b1;
              st_set_dirty = 1'b1;
              cpu_ready    = 1'b1;
            end else begin
              state_d = S_BYPASS;
              upd_d   = 1'b1;
            end
          end else if (we && policy == POL_WTNA) begin
            state_d = S_BYPASS;
            upd_d   = 1'b0;
          end else if (victim_dirty) begin
            state_d = S_EVICT;
            beat_d  = '0;
            maint_d = 1'b0;
          end else begin
            state_d = S_FILL;
            beat_d  = '0;
          end
        end
      end
      S_EVICT: begin
        st_wsel = beat_q;
        if (mem_ack) begin
          beat_d = beat_q + OW'(1);
          if (beat_q == LAST) begin
            if (maint_q) begin
              st_clr_valid = 1'b1;
              cpu_ready    = 1'b1;
              state_d      = S_IDLE;
            end else begin
              state_d = S_FILL;
            end
          end
        end
      end
      S_FILL: begin
        st_wsel  = beat_q;
        st_wdata = mem_rdata;
        if (mem_ack) begin
          st_wr_word = 1'b1;
          beat_d     = beat_q + OW'(1);
          if (beat_q == LAST) begin
            st_fill_last = 1'b1;
            state_d      = S_IDLE;
          end
        end
      end
      S_BYPASS: begin
        if (mem_ack) begin
          cpu_ready  = 1'b1;
          st_wr_word = upd_q;
          state_d    = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      maint_q <= 1'b0;
      upd_q   <= 1'b0;
      pol_q   <= POL_UNC;
    end else begin
      state_q <= state_d;
      pol_q   <= policy;
      if (state_d != state_q || mem_ack) begin
        beat_q  <= beat_d;
        maint_q <= maint_d;
        upd_q   <= upd_d;
      end
    end
  end

  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_EVICT) || (state_q == S_BYPASS && we);
  assign mem_wdata = (state_q == S_EVICT) ? line_word : cpu_wdata;
  assign cpu_rdata = (state_q == S_BYPASS) ? mem_rdata : line_word;

  always_comb begin
    unique case (state_q)
      S_EVICT: mem_addr = {3'b000, line_tag, a_idx, beat_q, 2'b00};
      S_FILL:  mem_addr = {3'b000, a_tag, a_idx, beat_q, 2'b00};
      default: mem_addr = paddr;
    endcase
  end

  AST_WB_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && op == OP_ACCESS && cacheable && policy == POL_WBWA && hit)
    |=> !mem_req); // R5
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_UNC_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && op == OP_ACCESS && bypass) |-> !cpu_ready); // R10
endmodule

// File: rtl/polcache.sv
module polcache
  import polcache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    policy,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_op,
  input  logic [31:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(LINES);
  localparam int OW = $clog2(WORDS);
  localparam int TW = 27 - IW - OW;

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [31:0]      paddr;
  logic             cacheable;
  logic [TW-1:0]    a_tag, line_tag;
  logic [IW-1:0]    a_idx;
  logic [OW-1:0]    a_word, st_wsel;
  logic [DW-1:0]    st_wdata, line_word;
  logic             line_valid, line_dirty;
  logic             st_wr_word, st_set_dirty, st_fill_last, st_clr_valid, st_flush;
  logic [LINES-1:0] valid_vec, dirty_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  polcache_alias u_alias (
    .vaddr     (cpu_addr),
    .paddr     (paddr),
    .cacheable (cacheable)
  );

  assign a_word = paddr[OW+1:2];
  assign a_idx  = paddr[IW+OW+1:OW+2];
  assign a_tag  = paddr[28:IW+OW+2];

  polcache_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW), .TW(TW)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .idx       (a_idx),
    .wsel      (st_wsel),
    .wdata     (st_wdata),
    .tag_in    (a_tag),
    .wr_word   (st_wr_word),
    .set_dirty (st_set_dirty),
    .fill_last (st_fill_last),
    .clr_valid (st_clr_valid),
    .flush     (st_flush),
    .rd_tag    (line_tag),
    .rd_valid  (line_valid),
    .rd_dirty  (line_dirty),
    .rd_word   (line_word),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec)
  );

  polcache_fsm #(.LINES(LINES), .WORDS(WORDS), .DW(DW), .TW(TW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .policy       (policy),
    .req          (cpu_req),
    .we           (cpu_we),
    .op           (cpu_op),
    .cacheable    (cacheable),
    .a_tag        (a_tag),
    .a_idx        (a_idx),
    .a_word       (a_word),
    .paddr        (paddr),
    .cpu_wdata    (cpu_wdata),
    .line_tag     (line_tag),
    .line_valid   (line_valid),
    .line_dirty   (line_dirty),
    .line_word    (line_word),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .cpu_ready    (cpu_ready),
    .cpu_rdata    (cpu_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .st_wsel      (st_wsel),
    .st_wdata     (st_wdata),
    .st_wr_word   (st_wr_word),
    .st_set_dirty (st_set_dirty),
    .st_fill_last (st_fill_last),
    .st_clr_valid (st_clr_valid),
    .st_flush     (st_flush)
  );

  AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dirty_vec & ~$past(dirty_vec)) != '0) |-> ($past(policy) == POL_WBWA)); // R7
  AST_UNC_FLUSH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pol_uncached(policy) && !pol_uncached($past(policy))) |=> (valid_vec == '0)); // R14
  AST_WBINV_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_ready && cpu_op == OP_WBINV) |=> !valid_vec[$past(a_idx)]); // R13
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_we && $past(mem_req && mem_we)) |-> $past(mem_ack)); // R6
endmodule

// File: tb/polcache_bench.sv
`timescale 1ns/1ps
module polcache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  policy = 3'd3;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [31:0] cpu_addr = 32'h0, cpu_wdata = 32'h0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  logic [31:0] mem [0:1023];
  logic        log_we [0:63];
  logic [31:0] log_ad [0:63];
  int          tr_n = 0;
  logic        dma_go = 1'b0;
  logic [9:0]  dma_ix = '0;
  logic [31:0] dma_val = '0;

  int vectors = 0, fails = 0;
  int n0, nw, nr, cyc;
  logic [31:0] rd;

  always #5 clk = ~clk;

  polcache u_polcache (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hA500_0000 + 32'(i * 4);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[11:2]];
        log_we[tr_n[5:0]] <= mem_we;
        log_ad[tr_n[5:0]] <= mem_addr;
        tr_n <= tr_n + 1;
      end
      if (dma_go) mem[dma_ix] <= dma_val;
    end
  end

  function automatic logic [31:0] orig(input logic [31:0] p);
    return 32'hA500_0000 + p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic we, input logic [31:0] a,
                        input logic [31:0] wd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    n0 = tr_n; cyc = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    nw = 0; nr = 0;
    for (int k = n0; k < tr_n; k++) begin
      if (log_we[k % 64]) nw++; else nr++;
    end
  endtask

  task automatic set_pol(input logic [2:0] p);
    @(negedge clk); policy = p;
    @(negedge clk);
  endtask

  task automatic dma_write(input logic [31:0] p, input logic [31:0] v);
    @(negedge clk); dma_go = 1'b1; dma_ix = p[11:2]; dma_val = v;
    @(negedge clk); dma_go = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R3 reset cpu_ready", {31'b0, cpu_ready}, 32'd0);
    chk("R3 reset mem_req", {31'b0, mem_req}, 32'd0);

    // R4 / R3 sweep over every word of 16 lines, write-back policy
    for (int i = 0; i < 64; i++) begin
      logic [31:0] p;
      p = 32'(i * 4);
      access(2'd0, 1'b0, 32'h8000_0000 | p, 32'h0);
      chk("R4 sweep data", rd, orig(p));
      if (i % 4 == 0) begin
        logic ok;
        ok = (nr == 4) && (nw == 0);
        for (int k = 0; k < 4; k++)
          if (log_ad[(n0 + k) % 64] !== p + 32'(k * 4)) ok = 1'b0;
        chk("R4 miss latency", 32'(cyc), 32'd9);
        chk("R4 fill order", {31'b0, ok}, 32'd1);
      end else begin
        chk("R3 hit latency", 32'(cyc), 32'd0);
        chk("R3 hit no bus", 32'(nr + nw), 32'd0);
      end
    end

    // R5 write-back write hit
    access(2'd0, 1'b1, 32'h8000_0004, 32'h1111_0004);
    chk("R5 wb hit latency", 32'(cyc), 32'd0);
    chk("R5 wb hit no bus", 32'(nr + nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0004, 32'h0);
    chk("R5 wb hit readback", rd, 32'h1111_0004);
    access(2'd0, 1'b0, 32'hA000_0004, 32'h0);
    chk("R10 uncached read memory old", rd, orig(32'h004));
    chk("R10 uncached read latency", 32'(cyc), 32'd2);

    // R6 dirty eviction before refill
    access(2'd0, 1'b0, 32'h8000_0104, 32'h0);
    chk("R6 dirty miss latency", 32'(cyc), 32'd17);
    chk("R6 dirty miss data", rd, orig(32'h104));
    begin
      logic ok;
      ok = (nw == 4) && (nr == 4);
      for (int k = 0; k < 4; k++) begin
        if (log_we[(n0 + k) % 64] !== 1'b1 || log_ad[(n0 + k) % 64] !== 32'(k * 4)) ok = 1'b0;
        if (log_we[(n0 + 4 + k) % 64] !== 1'b0 || log_ad[(n0 + 4 + k) % 64] !== 32'h100 + 32'(k * 4)) ok = 1'b0;
      end
      chk("R6 writeback then fill order", {31'b0, ok}, 32'd1);
    end
    access(2'd0, 1'b0, 32'hA000_0004, 32'h0);
    chk("R6 written back word", rd, 32'h1111_0004);

    // R7 write-through with allocate
    set_pol(3'd1);
    access(2'd0, 1'b0, 32'h8000_0200, 32'h0);
    chk("R7 fill latency", 32'(cyc), 32'd9);
    access(2'd0, 1'b1, 32'h8000_0200, 32'h2222_0001);
    chk("R7 wt hit latency", 32'(cyc), 32'd2);
    chk("R7 wt hit one write", 32'(nw), 32'd1);
    access(2'd0, 1'b1, 32'h8000_0200, 32'h2222_0002);
    chk("R7 back-to-back write", 32'(nw), 32'd1);
    access(2'd0, 1'b0, 32'h8000_0200, 32'h0);
    chk("R7 line updated", rd, 32'h2222_0002);
    chk("R7 line hit", 32'(cyc), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0300, 32'h0);
    chk("R7 eviction clean latency", 32'(cyc), 32'd9);
    chk("R7 eviction no writeback", 32'(nw), 32'd0);
    access(2'd0, 1'b0, 32'hA000_0200, 32'h0);
    chk("R7 memory updated", rd, 32'h2222_0002);
    access(2'd0, 1'b1, 32'h8000_0410, 32'h4444_0010);
    chk("R9 wt-wa miss latency", 32'(cyc), 32'd11);
    chk("R9 wt-wa miss reads", 32'(nr), 32'd4);
    chk("R9 wt-wa miss writes", 32'(nw), 32'd1);
    access(2'd0, 1'b0, 32'h8000_0410, 32'h0);
    chk("R9 wt-wa allocated hit", 32'(cyc), 32'd0);
    chk("R9 wt-wa allocated data", rd, 32'h4444_0010);

    // R8 write-through without allocate
    set_pol(3'd0);
    access(2'd0, 1'b1, 32'h8000_0520, 32'h5555_0020);
    chk("R8 nwa miss latency", 32'(cyc), 32'd2);
    chk("R8 nwa miss no read", 32'(nr), 32'd0);
    chk("R8 nwa miss one write", 32'(nw), 32'd1);
    access(2'd0, 1'b0, 32'h8000_0520, 32'h0);
    chk("R8 not allocated", 32'(cyc), 32'd9);
    chk("R8 read from memory", rd, 32'h5555_0020);
    access(2'd0, 1'b1, 32'h8000_0524, 32'h5555_0024);
    chk("R8 nwa hit one write", 32'(nw), 32'd1);
    access(2'd0, 1'b0, 32'h8000_0524, 32'h0);
    chk("R8 nwa hit line", rd, 32'h5555_0024);
    chk("R8 nwa hit latency", 32'(cyc), 32'd0);

    // R9 write-back with allocate write miss
    set_pol(3'd3);
    access(2'd0, 1'b1, 32'h8000_0630, 32'h6666_0030);
    chk("R9 wb-wa miss latency", 32'(cyc), 32'd9);
    chk("R9 wb-wa miss reads", 32'(nr), 32'd4);
    chk("R9 wb-wa miss no write", 32'(nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0630, 32'h0);
    chk("R9 wb-wa data", rd, 32'h6666_0030);
    access(2'd0, 1'b0, 32'hA000_0630, 32'h0);
    chk("R9 wb-wa memory untouched", rd, orig(32'h630));

    // R10 uncached write leaves cached copy
    access(2'd0, 1'b0, 32'h8000_0300, 32'h0);
    chk("R10 line cached", 32'(cyc), 32'd0);
    access(2'd0, 1'b1, 32'hA000_0300, 32'h7777_0300);
    chk("R10 uncached write", 32'(nw), 32'd1);
    access(2'd0, 1'b0, 32'h8000_0300, 32'h0);
    chk("R10 cache unchanged", rd, orig(32'h300));
    access(2'd0, 1'b0, 32'hA000_0300, 32'h0);
    chk("R10 memory changed", rd, 32'h7777_0300);

    // R11 other master, R12 invalidate
    dma_write(32'h044, 32'h8888_0044);
    access(2'd0, 1'b0, 32'h8000_0044, 32'h0);
    chk("R11 stale hit", rd, orig(32'h044));
    access(2'd1, 1'b0, 32'h8000_0040, 32'h0);
    chk("R12 inv latency", 32'(cyc), 32'd0);
    chk("R12 inv no bus", 32'(nr + nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0044, 32'h0);
    chk("R11 fresh after inv", rd, 32'h8888_0044);
    chk("R12 miss after inv", 32'(cyc), 32'd9);
    access(2'd0, 1'b1, 32'h8000_0048, 32'h9999_0048);
    access(2'd1, 1'b0, 32'h8000_0048, 32'h0);
    chk("R12 dirty inv no write", 32'(nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0048, 32'h0);
    chk("R12 dirty data lost", rd, orig(32'h048));

    // R13 writeback-invalidate
    access(2'd0, 1'b1, 32'h8000_0054, 32'hBBBB_0054);
    access(2'd2, 1'b0, 32'h8000_0050, 32'h0);
    chk("R13 wbinv latency", 32'(cyc), 32'd8);
    chk("R13 wbinv writes", 32'(nw), 32'd4);
    access(2'd0, 1'b0, 32'hA000_0054, 32'h0);
    chk("R13 memory has line", rd, 32'hBBBB_0054);
    access(2'd0, 1'b0, 32'h8000_0054, 32'h0);
    chk("R13 line invalid", 32'(cyc), 32'd9);
    access(2'd2, 1'b0, 32'h8000_0050, 32'h0);
    chk("R13 clean wbinv latency", 32'(cyc), 32'd0);
    chk("R13 clean wbinv no bus", 32'(nr + nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0058, 32'h0);
    chk("R13 clean wbinv invalid", 32'(cyc), 32'd9);

    // R14 / R1 uncached policy
    access(2'd0, 1'b1, 32'h8000_0064, 32'hCCCC_0064);
    set_pol(3'd2);
    access(2'd0, 1'b0, 32'h8000_0070, 32'h0);
    chk("R1 code 2 bypass latency", 32'(cyc), 32'd2);
    chk("R1 code 2 data", rd, orig(32'h070));
    set_pol(3'd5);
    access(2'd0, 1'b0, 32'h8000_0074, 32'h0);
    chk("R1 code 5 bypass latency", 32'(cyc), 32'd2);
    set_pol(3'd3);
    access(2'd0, 1'b0, 32'h8000_0064, 32'h0);
    chk("R14 flushed miss", 32'(cyc), 32'd9);
    chk("R14 dirty dropped", rd, orig(32'h064));
    chk("R14 no writeback", 32'(nw), 32'd0);
    access(2'd0, 1'b0, 32'h8000_0070, 32'h0);
    chk("R14 other line flushed", 32'(cyc), 32'd9);

    // R2 addresses outside both windows
    access(2'd0, 1'b0, 32'h0000_0080, 32'h0);
    chk("R2 low address bypass", 32'(cyc), 32'd2);
    chk("R2 low address data", rd, orig(32'h080));
    access(2'd0, 1'b1, 32'hC000_0084, 32'hDDDD_0084);
    chk("R2 high address write", 32'(nw), 32'd1);
    chk("R2 physical address", log_ad[n0 % 64], 32'h0000_0084);
    access(2'd0, 1'b0, 32'hA000_0084, 32'h0);
    chk("R2 alias data", rd, 32'hDDDD_0084);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule